// File: doc/BRIEF.md
# Package idle state resolver

This block merges the idle requests of the cores in a small multi-core package into one package idle state. Each core presents a 3-bit idle code. The package is allowed to go only as deep as the shallowest core asks for, and never deeper than the platform permits. Because the package may end up shallower than its cores, a core can be deeper than the package. The block sequences entry into the deep coordinated states through an intermediate step. It also decides what happens when a break event arrives: a core interrupt, masked or unmasked, or a memory or snoop access.

The block is built around a four-state sequencer:
- `SQ_TRACK` follows the resolved target.
- `SQ_INTERIM` holds the package in C2 for one cycle on the way into C3 or C6.
- `SQ_SERVICE` keeps the package in C0 while a break is serviced, then returns it to the state it had saved.
- `SQ_AWAKE` keeps the package in C0 after an unmasked core interrupt, until the woken core itself requests C0.

Transitions:
- Track to interim: a deep target is reached from C0, C1 or C1E.
- Interim to track: after one cycle.
- Track or interim to service: a masked core break, or a memory break.
- Track, interim or service to awake: an unmasked core break.
- Service to track or interim: the access ends and the platform hold is low.
- Awake to track: the woken core requests C0.

Alongside the package state, the block produces an execution-allowed status, a request to enter a coordinated state, and a one-cycle wake pulse per core.

Top module: `pkg_idle_resolver`

## Requirements
- R1: Idle codes are C0=0, C1=1, C1E=2, C2=3, C3=4, C6=5. A request code of 6 or 7, on a core or on the platform limit, is treated as C6 (5). `pkg_state` only ever shows codes 0 to 5.
- R2: In `SQ_TRACK`, the target is the smaller of the lowest clamped core request and the clamped `plat_limit`. A changed target appears on `pkg_state` at the first clock edge that samples it.
- R3: The package moves directly between idle states without passing through C0. Examples are C1 to C2, C2 to C3, C3 to C6 and C6 to C1.
- R4: A move to C3 or C6 from C0, C1 or C1E first shows C2 for exactly one cycle. The destination follows at the next edge.
- R5: An unmasked core break (`brk_core_valid`=1, `brk_core_masked`=0) sets `wake_core[brk_core_id]` for one cycle and forces `pkg_state` to C0 at the next edge. The package stays at C0 until the woken core's request is C0, and tracking resumes one cycle after that.
- R6: A masked core break also pulses `wake_core`. The package shows C0 for one cycle, then returns to the state it held before the break, going through C2 first if that state is C3 or C6.
- R7: While `brk_mem_valid` is high, `pkg_state` is C0 from the next edge on. Once it drops with `plat_hold` low, the package returns to its pre-break state at the next edge.
- R8: If `plat_hold` is high when a serviced break ends, the package stays at C0 until `plat_hold` drops, then returns to the saved state.
- R9: `exec_allowed` is 0 one cycle after every core requests C3 or deeper, and 1 otherwise.
- R10: `coord_req` is 1 one cycle after every core requests C3 or deeper, provided the sequencer is then in `SQ_TRACK` or `SQ_INTERIM`. It is 0 while a break is serviced or a woken core is awaited.
- R11: During reset, `pkg_state` is C0, `exec_allowed` is 1, and `coord_req` and `wake_core` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req_flat | input | N_CORES*3 | Per-core idle code, core i at bits [3i+2:3i] |
| plat_limit | input | 3 | Deepest package state the platform permits |
| brk_core_valid | input | 1 | One-cycle core interrupt break |
| brk_core_masked | input | 1 | The core break is masked |
| brk_core_id | input | CORE_ID_W | Target core of the break |
| brk_mem_valid | input | 1 | Memory or snoop access in progress |
| plat_hold | input | 1 | Platform asks to stay shallow after servicing |
| pkg_state | output | 3 | Registered package idle code |
| coord_req | output | 1 | Request to enter a coordinated package state |
| exec_allowed | output | 1 | Execution-allowed status |
| wake_core | output | N_CORES | One-cycle wake pulse per core |

## Verification
The assertions assume three things about the inputs. `brk_core_id` always names an existing core. A core break is a one-cycle pulse. `brk_mem_valid` is a level that stays high for the whole access. The stimulus keeps to these assumptions: it draws core ids only below the core count, clears the core-break strobe after one cycle, and holds memory breaks for a drawn length of one to four cycles. Core requests are redrawn in phases, some of which put every core at C3 or deeper. This lets coordinated entry and waking all occur within a single run.

// File: rtl/psr_pkg.sv
`timescale 1ns/1ps
package psr_pkg;

    typedef enum logic [2:0] {
        PS_C0  = 3'd0,
        PS_C1  = 3'd1,
        PS_C1E = 3'd2,
        PS_C2  = 3'd3,
        PS_C3  = 3'd4,
        PS_C6  = 3'd5
    } pstate_e;

    typedef enum logic [1:0] {
        SQ_TRACK,
        SQ_INTERIM,
        SQ_SERVICE,
        SQ_AWAKE
    } seq_e;

    localparam int CODE_W = 3;

    // Codes beyond the deepest state saturate to C6.
    function automatic pstate_e to_state(logic [CODE_W-1:0] code);
        return (code > 3'd5) ? PS_C6 : pstate_e'(code);
    endfunction

endpackage

// File: rtl/psr_min_reduce.sv
`timescale 1ns/1ps
module psr_min_reduce
    import psr_pkg::*;
#(
    parameter int N_CORES = 4
) (
    input  logic [N_CORES*CODE_W-1:0] req_raw,
    output logic [N_CORES*CODE_W-1:0] req_clamped,
    output logic [CODE_W-1:0]         min_req,
    output logic                      all_deep
);

    genvar g;
    generate
        for (g = 0; g < N_CORES; g++) begin : g_clamp
            assign req_clamped[g*CODE_W +: CODE_W] = to_state(req_raw[g*CODE_W +: CODE_W]);
        end
    endgenerate

    always_comb begin
        min_req = PS_C6;
        for (int i = 0; i < N_CORES; i++) begin
            if (req_clamped[i*CODE_W +: CODE_W] < min_req)
                min_req = req_clamped[i*CODE_W +: CODE_W];
        end
        all_deep = (min_req >= PS_C3);
    end

endmodule

// File: rtl/psr_wake_decode.sv
`timescale 1ns/1ps
module psr_wake_decode #(
    parameter int N_CORES   = 4,
    parameter int CORE_ID_W = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 brk_core_valid,
    input  logic [CORE_ID_W-1:0] brk_core_id,
    output logic [N_CORES-1:0]   wake_core
);

    genvar g;
    generate
        for (g = 0; g < N_CORES; g++) begin : g_wake
            always_ff @(posedge clk) begin
                if (!rst_n) wake_core[g] <= 1'b0;
                else        wake_core[g] <= brk_core_valid && (brk_core_id == CORE_ID_W'(g));
            end
        end
    endgenerate

endmodule

// File: rtl/psr_sequencer.sv
`timescale 1ns/1ps
module psr_sequencer
    import psr_pkg::*;
#(
    parameter int N_CORES   = 4,
    parameter int CORE_ID_W = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CODE_W-1:0]         min_req,
    input  logic                      all_deep,
    input  logic [N_CORES*CODE_W-1:0] req_clamped,
    input  logic [CODE_W-1:0]         plat_limit,
    input  logic                      brk_core_valid,
    input  logic                      brk_core_masked,
    input  logic [CORE_ID_W-1:0]      brk_core_id,
    input  logic                      brk_mem_valid,
    input  logic                      plat_hold,
    output logic [CODE_W-1:0]         pkg_state,
    output logic                      coord_req,
    output logic                      exec_allowed
);

    seq_e                 seq_q, seq_d;
    pstate_e              pkg_q, pkg_d;
    pstate_e              saved_q, saved_d;
    pstate_e              dest_q, dest_d;
    logic [CORE_ID_W-1:0] id_q, id_d;
    logic                 coord_q, coord_d;
    logic                 ea_q, ea_d;

    pstate_e target;
    pstate_e goal;
    logic    take_goal;
    logic    hard_wake;
    logic    woken_idle;

    always_comb begin
        target     = (to_state(min_req) < to_state(plat_limit)) ? to_state(min_req)
                                                                 : to_state(plat_limit);
        hard_wake  = brk_core_valid && !brk_core_masked;
        woken_idle = (req_clamped[int'(id_q)*CODE_W +: CODE_W] == PS_C0);
    end

    // Next-state and next-output logic.
    always_comb begin
        seq_d     = seq_q;
        pkg_d     = pkg_q;
        saved_d   = saved_q;
        dest_d    = dest_q;
        id_d      = id_q;
        goal      = target;
        take_goal = 1'b0;
        unique case (seq_q)
            SQ_TRACK, SQ_INTERIM: begin
                if (hard_wake) begin
                    seq_d = SQ_AWAKE;
                    pkg_d = PS_C0;
                    id_d  = brk_core_id;
                end else if (brk_core_valid || brk_mem_valid) begin
                    seq_d   = SQ_SERVICE;
                    pkg_d   = PS_C0;
                    saved_d = pkg_q;
                end else if (seq_q == SQ_INTERIM) begin
                    seq_d = SQ_TRACK;
                    pkg_d = dest_q;
                end else begin
                    take_goal = 1'b1;
                end
            end
            SQ_SERVICE: begin
                if (hard_wake) begin
                    seq_d = SQ_AWAKE;
                    id_d  = brk_core_id;
                end else if (!brk_mem_valid && !plat_hold) begin
                    goal      = saved_q;
                    take_goal = 1'b1;
                end
            end
            SQ_AWAKE: begin
                if (hard_wake) id_d = brk_core_id;
                else if (woken_idle) seq_d = SQ_TRACK;
            end
        endcase
        if (take_goal) begin
            if (goal >= PS_C3 && pkg_q <= PS_C1E) begin
                seq_d  = SQ_INTERIM;
                pkg_d  = PS_C2;
                dest_d = goal;
            end else begin
                seq_d = SQ_TRACK;
                pkg_d = goal;
            end
        end
        coord_d = all_deep && (seq_d == SQ_TRACK || seq_d == SQ_INTERIM);
        ea_d    = !all_deep;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q   <= SQ_TRACK;
            pkg_q   <= PS_C0;
            saved_q <= PS_C0;
            dest_q  <= PS_C0;
            id_q    <= '0;
            coord_q <= 1'b0;
            ea_q    <= 1'b1;
        end else begin
            seq_q   <= seq_d;
            pkg_q   <= pkg_d;
            saved_q <= saved_d;
            dest_q  <= dest_d;
            id_q    <= id_d;
            coord_q <= coord_d;
            ea_q    <= ea_d;
        end
    end

    assign pkg_state    = pkg_q;
    assign coord_req    = coord_q;
    assign exec_allowed = ea_q;

endmodule

// File: rtl/pkg_idle_resolver.sv
`timescale 1ns/1ps
module pkg_idle_resolver
    import psr_pkg::*;
#(
    parameter int N_CORES   = 4,
    parameter int CORE_ID_W = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_CORES*3-1:0]      core_req_flat,
    input  logic [2:0]                plat_limit,
    input  logic                      brk_core_valid,
    input  logic                      brk_core_masked,
    input  logic [CORE_ID_W-1:0]      brk_core_id,
    input  logic                      brk_mem_valid,
    input  logic                      plat_hold,
    output logic [2:0]                pkg_state,
    output logic                      coord_req,
    output logic                      exec_allowed,
    output logic [N_CORES-1:0]        wake_core
);

    logic [N_CORES*CODE_W-1:0] req_clamped;
    logic [CODE_W-1:0]         min_req;
    logic                      all_deep;

    psr_min_reduce #(.N_CORES(N_CORES)) u_min (
        .req_raw     (core_req_flat),
        .req_clamped (req_clamped),
        .min_req     (min_req),
        .all_deep    (all_deep)
    );

    psr_sequencer #(.N_CORES(N_CORES), .CORE_ID_W(CORE_ID_W)) u_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .min_req         (min_req),
        .all_deep        (all_deep),
        .req_clamped     (req_clamped),
        .plat_limit      (plat_limit),
        .brk_core_valid  (brk_core_valid),
        .brk_core_masked (brk_core_masked),
        .brk_core_id     (brk_core_id),
        .brk_mem_valid   (brk_mem_valid),
        .plat_hold       (plat_hold),
        .pkg_state       (pkg_state),
        .coord_req       (coord_req),
        .exec_allowed    (exec_allowed)
    );

    psr_wake_decode #(.N_CORES(N_CORES), .CORE_ID_W(CORE_ID_W)) u_wake (
        .clk            (clk),
        .rst_n          (rst_n),
        .brk_core_valid (brk_core_valid),
        .brk_core_id    (brk_core_id),
        .wake_core      (wake_core)
    );

endmodule

// File: rtl/pkg_idle_resolver_chk.sv
`timescale 1ns/1ps
module pkg_idle_resolver_chk #(
    parameter int N_CORES   = 4,
    parameter int CORE_ID_W = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 brk_core_valid,
    input logic                 brk_core_masked,
    input logic                 brk_mem_valid,
    input logic [2:0]           pkg_state,
    input logic                 coord_req,
    input logic                 exec_allowed,
    input logic [N_CORES-1:0]   wake_core
);

    a_r1_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        pkg_state <= 3'd5);

    a_r4_deep_via_c2: assert property (@(posedge clk) disable iff (!rst_n)
        (pkg_state >= 3'd4) |-> ($past(pkg_state) >= 3'd3));

    a_r5_unmasked_to_c0: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_core_valid && !brk_core_masked) |=> (pkg_state == 3'd0));

    a_r5_wake_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        brk_core_valid |=> ($countones(wake_core) == 1));

    a_r5_wake_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !brk_core_valid |=> (wake_core == '0));

    a_r5_wake_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wake_core));

    a_r7_mem_to_c0: assert property (@(posedge clk) disable iff (!rst_n)
        brk_mem_valid |=> (pkg_state == 3'd0));

    a_r10_coord_excl_ea: assert property (@(posedge clk) disable iff (!rst_n)
        coord_req |-> !exec_allowed);

endmodule

bind pkg_idle_resolver pkg_idle_resolver_chk #(.N_CORES(N_CORES), .CORE_ID_W(CORE_ID_W)) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .brk_core_valid  (brk_core_valid),
    .brk_core_masked (brk_core_masked),
    .brk_mem_valid   (brk_mem_valid),
    .pkg_state       (pkg_state),
    .coord_req       (coord_req),
    .exec_allowed    (exec_allowed),
    .wake_core       (wake_core)
);

// File: tb/pkg_idle_resolver_tb_top.sv
`timescale 1ns/1ps
module pkg_idle_resolver_tb_top;

    localparam int NC  = 4;
    localparam int IDW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [2:0]      req [NC];
    logic [NC*3-1:0] core_req_flat;
    logic [2:0]      plat_limit = 3'd5;
    logic            brk_core_valid = 1'b0;
    logic            brk_core_masked = 1'b0;
    logic [IDW-1:0]  brk_core_id = '0;
    logic            brk_mem_valid = 1'b0;
    logic            plat_hold = 1'b0;
    logic [2:0]      pkg_state;
    logic            coord_req;
    logic            exec_allowed;
    logic [NC-1:0]   wake_core;

    int n_checks = 0;
    int n_errors = 0;
    string tag = "R11";

    // Reference model state: mode 0 track, 1 interim, 2 service, 3 awake.
    int m_pkg = 0, m_mode = 0, m_saved = 0, m_dest = 0, m_id = 0;
    int m_coord = 0, m_ea = 1, m_wake = 0;

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NC; i++) core_req_flat[i*3 +: 3] = req[i];
    end

    pkg_idle_resolver #(.N_CORES(NC)) dut_i (
        .clk(clk), .rst_n(rst_n), .core_req_flat(core_req_flat), .plat_limit(plat_limit),
        .brk_core_valid(brk_core_valid), .brk_core_masked(brk_core_masked),
        .brk_core_id(brk_core_id), .brk_mem_valid(brk_mem_valid), .plat_hold(plat_hold),
        .pkg_state(pkg_state), .coord_req(coord_req), .exec_allowed(exec_allowed),
        .wake_core(wake_core));

    function automatic int sat(int v);
        return (v > 5) ? 5 : v;
    endfunction

    task automatic chk(string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_step();
        int lo, tgt, goal, nmode;
        bit use_goal, hard;
        lo = 5;
        for (int i = 0; i < NC; i++) if (sat(int'(req[i])) < lo) lo = sat(int'(req[i]));
        tgt = (lo < sat(int'(plat_limit))) ? lo : sat(int'(plat_limit));
        hard = brk_core_valid && !brk_core_masked;
        use_goal = 0;
        goal = tgt;
        nmode = m_mode;
        if (!rst_n) begin
            m_pkg = 0; m_mode = 0; m_saved = 0; m_dest = 0; m_id = 0;
            m_coord = 0; m_ea = 1; m_wake = 0;
            return;
        end
        m_wake = brk_core_valid ? (1 << int'(brk_core_id)) : 0;
        if (m_mode <= 1) begin
            if (hard) begin nmode = 3; m_pkg = 0; m_id = int'(brk_core_id); end
            else if (brk_core_valid || brk_mem_valid) begin nmode = 2; m_saved = m_pkg; m_pkg = 0; end
            else if (m_mode == 1) begin nmode = 0; m_pkg = m_dest; end
            else use_goal = 1;
        end else if (m_mode == 2) begin
            if (hard) begin nmode = 3; m_id = int'(brk_core_id); end
            else if (!brk_mem_valid && !plat_hold) begin use_goal = 1; goal = m_saved; end
        end else begin
            if (hard) m_id = int'(brk_core_id);
            else if (sat(int'(req[m_id])) == 0) nmode = 0;
        end
        if (use_goal) begin
            if (goal >= 4 && m_pkg <= 2) begin nmode = 1; m_pkg = 3; m_dest = goal; end
            else begin nmode = 0; m_pkg = goal; end
        end
        m_mode  = nmode;
        m_coord = (lo >= 4 && nmode <= 1) ? 1 : 0;
        m_ea    = (lo >= 4) ? 0 : 1;
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        #1;
        chk("pkg_state", int'(pkg_state), m_pkg);
        chk("coord_req", int'(coord_req), m_coord);
        chk("exec_allowed", int'(exec_allowed), m_ea);
        chk("wake_core", int'(wake_core), m_wake);
        @(negedge clk);
    endtask

    task automatic set_all(int v);
        for (int i = 0; i < NC; i++) req[i] = 3'(v);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        set_all(0);
        @(negedge clk);
        tick(); tick();
        tag = "R11";
        chk("reset pkg", int'(pkg_state), 0);
        chk("reset ea", int'(exec_allowed), 1);
        chk("reset coord", int'(coord_req), 0);
        chk("reset wake", int'(wake_core), 0);
        rst_n = 1'b1;

        tag = "R2";
        req[0] = 1; req[1] = 2; req[2] = 5; req[3] = 4;
        tick(); chk("min of cores", int'(pkg_state), 1);
        set_all(3); plat_limit = 3'd1;
        tick(); chk("limited", int'(pkg_state), 1);
        tag = "R3";
        plat_limit = 3'd5;
        tick(); chk("C1 to C2 direct", int'(pkg_state), 3);
        set_all(4);
        tick(); chk("C2 to C3 direct", int'(pkg_state), 4);
        tag = "R9";  chk("ea low all deep", int'(exec_allowed), 0);
        tag = "R10"; chk("coord high all deep", int'(coord_req), 1);
        tag = "R1";
        set_all(7);
        tick(); chk("code 7 as C6", int'(pkg_state), 5);
        tag = "R3";
        set_all(1);
        tick(); chk("C6 to C1 direct", int'(pkg_state), 1);
        tag = "R4";
        set_all(5);
        tick(); chk("interim C2", int'(pkg_state), 3);
        tick(); chk("reach C6", int'(pkg_state), 5);

        tag = "R5";
        brk_core_valid = 1; brk_core_masked = 0; brk_core_id = 2;
        tick(); chk("unmasked to C0", int'(pkg_state), 0);
        chk("wake core 2", int'(wake_core), 4);
        tag = "R10"; chk("coord low when awake", int'(coord_req), 0);
        tag = "R5";
        brk_core_valid = 0;
        tick(); chk("held C0", int'(pkg_state), 0);
        chk("wake cleared", int'(wake_core), 0);
        tick(); chk("still C0", int'(pkg_state), 0);
        req[2] = 0;
        tick(); chk("exit awake", int'(pkg_state), 0);
        req[2] = 5;
        tick(); chk("reentry C2", int'(pkg_state), 3);
        tick(); chk("reentry C6", int'(pkg_state), 5);

        tag = "R6";
        brk_core_valid = 1; brk_core_masked = 1; brk_core_id = 1;
        tick(); chk("masked C0", int'(pkg_state), 0);
        chk("wake core 1", int'(wake_core), 2);
        brk_core_valid = 0; brk_core_masked = 0;
        tick(); chk("back via C2", int'(pkg_state), 3);
        tick(); chk("back to C6", int'(pkg_state), 5);

        tag = "R7";
        plat_limit = 3'd1;
        tick(); chk("limit to C1", int'(pkg_state), 1);
        brk_mem_valid = 1;
        for (int k = 0; k < 3; k++) begin
            tick(); chk("mem C0", int'(pkg_state), 0);
        end
        brk_mem_valid = 0;
        tick(); chk("mem return", int'(pkg_state), 1);

        tag = "R8";
        plat_limit = 3'd5;
        tick(); tick();
        chk("deep again", int'(pkg_state), 5);
        brk_mem_valid = 1; plat_hold = 1;
        tick(); chk("mem C0", int'(pkg_state), 0);
        brk_mem_valid = 0;
        tick(); chk("hold C0", int'(pkg_state), 0);
        tick(); chk("hold C0 again", int'(pkg_state), 0);
        plat_hold = 0;
        tick(); chk("release via C2", int'(pkg_state), 3);
        tick(); chk("release C6", int'(pkg_state), 5);

        tag = "RND";
        void'($urandom(32'd20240611));
        begin
            int mem_left = 0;
            for (int cyc = 0; cyc < 4000; cyc++) begin
                if (cyc % 8 == 0) begin
                    bit deep = ($urandom % 3) == 0;
                    for (int i = 0; i < NC; i++)
                        req[i] = deep ? 3'(4 + $urandom % 4) : 3'($urandom % 8);
                end
                if ($urandom % 16 == 0) plat_limit = 3'($urandom % 8);
                brk_core_valid  = ($urandom % 20) == 0;
                brk_core_masked = $urandom % 2;
                brk_core_id     = IDW'($urandom % NC);
                if (mem_left > 0) mem_left--;
                else if ($urandom % 25 == 0) mem_left = 1 + $urandom % 4;
                brk_mem_valid = (mem_left > 0);
                if ($urandom % 10 == 0) plat_hold = ~plat_hold;
                tick();
            end
        end
        finish_run();
    end

endmodule